// File: doc/BRIEF.md
# Configurable Fan-Out Command Register

This block is the address/command register that sits between a memory controller and the loads on a memory module. On each rising clock edge it captures a parallel input word into a bank of flops and drives the captured value onto its outputs. A static mode input chooses between two arrangements. In wide mode every captured bit drives one output. In fan-out mode a narrower set of bits is used, and each bit drives two output copies so that each copy can serve half of the loads.

A second static input picks one of two pin arrangements for fan-out mode. One is a straight mapping. The other is a reversed mapping that suits the opposite board routing. Two active-low select inputs can freeze the outputs: when both are high, a clock edge captures nothing. An asynchronous active-low reset clears the register at once and overrides the select gating.

The configuration inputs are expected to be strapped or changed only while the register is idle. The output mapping follows them combinationally from the stored word.

Top module: `cmd_reg_buffer`

## Requirements
- R1: While `rst_ni` is low, `out_a_o` and `out_b_o` are all zero. Asserting reset clears them without waiting for a clock edge.
- R2: With `cfg_fan_i` = 0, `out_a_o` equals the `data_i` word taken at the most recent updating rising edge, and `out_b_o` is all zero.
- R3: With `cfg_fan_i` = 1 and `cfg_layout_b_i` = 0, captured bit i (i < NARROW_W) drives both `out_a_o[i]` and `out_b_o[i]`.
- R4: With `cfg_fan_i` = 1 and `cfg_layout_b_i` = 1, captured bit i drives both `out_a_o[NARROW_W-1-i]` and `out_b_o[NARROW_W-1-i]`.
- R5: With `cfg_fan_i` = 1, `out_a_o[WIDE_W-1:NARROW_W]` is zero, and `data_i[WIDE_W-1:NARROW_W]` has no effect on any output.
- R6: A rising edge at which `dcs_ni` and `csr_ni` are both high leaves both outputs unchanged.
- R7: A rising edge at which either select is low updates the register. With `csr_ni` low, the level of `dcs_ni` has no effect on the update.
- R8: Reset dominates the gating. Asserting `rst_ni` while both selects are high still clears the outputs, and they stay zero across clock edges for as long as reset is held.
- R9: After reset is released with `data_i` at zero, the outputs remain zero on every edge until a non-zero word is captured. That word then appears after one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Capture clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_fan_i | input | 1 | 0: wide one-to-one mode, 1: fan-out mode |
| cfg_layout_b_i | input | 1 | Fan-out pin arrangement: 0 straight, 1 reversed |
| dcs_ni | input | 1 | Select input, active low |
| csr_ni | input | 1 | Select input, active low |
| data_i | input | WIDE_W | Input command/address word |
| out_a_o | output | WIDE_W | Primary outputs, first copy in fan-out mode |
| out_b_o | output | NARROW_W | Second copy in fan-out mode, zero in wide mode |

## Verification
The bench uses the default widths of 25 for wide mode and 14 for fan-out mode. With these values, both the upper eleven bits that fan-out mode must ignore and the lower fourteen that it uses are exercised. Fourteen is even, so the reversed arrangement has no bit that maps onto itself. A swapped or mis-indexed mapping in layout B therefore shows up with asymmetric test words.

// File: rtl/crb_pkg.sv
package crb_pkg;
  // source bit feeding pair position pos in fan-out mode
  function automatic int unsigned pair_src(input int unsigned pos, input logic layout_b,
                                           input int unsigned n);
    return layout_b ? (n - 1 - pos) : pos;
  endfunction
endpackage

// File: rtl/crb_capture.sv
module crb_capture #(
  parameter int unsigned W = 25
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         gate_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (!gate_i) q_o <= d_i;
  end
endmodule

// File: rtl/crb_fanout.sv
module crb_fanout
  import crb_pkg::*;
#(
  parameter int unsigned WIDE_W   = 25,
  parameter int unsigned NARROW_W = 14
) (
  input  logic                fan_i,
  input  logic                layout_b_i,
  input  logic [WIDE_W-1:0]   word_i,
  output logic [WIDE_W-1:0]   out_a_o,
  output logic [NARROW_W-1:0] out_b_o
);
  for (genvar p = 0; p < int'(WIDE_W); p++) begin : g_pos
    if (p < int'(NARROW_W)) begin : g_pair
      logic bit_a, bit_b;
      assign bit_a = word_i[pair_src(p, 1'b0, NARROW_W)];
      assign bit_b = word_i[pair_src(p, 1'b1, NARROW_W)];
      assign out_a_o[p] = !fan_i ? word_i[p] : (layout_b_i ? bit_b : bit_a);
      assign out_b_o[p] = !fan_i ? 1'b0      : (layout_b_i ? bit_b : bit_a);
    end else begin : g_wide
      assign out_a_o[p] = fan_i ? 1'b0 : word_i[p];
    end
  end
endmodule

// File: rtl/cmd_reg_buffer.sv
module cmd_reg_buffer #(
  parameter int unsigned WIDE_W   = 25,
  parameter int unsigned NARROW_W = 14
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_fan_i,
  input  logic                cfg_layout_b_i,
  input  logic                dcs_ni,
  input  logic                csr_ni,
  input  logic [WIDE_W-1:0]   data_i,
  output logic [WIDE_W-1:0]   out_a_o,
  output logic [NARROW_W-1:0] out_b_o
);
  logic              hold;
  logic [WIDE_W-1:0] word_q;

  assign hold = dcs_ni & csr_ni;

  crb_capture #(.W(WIDE_W)) u_cap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .gate_i(hold),
    .d_i   (data_i),
    .q_o   (word_q)
  );

  crb_fanout #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_map (
    .fan_i     (cfg_fan_i),
    .layout_b_i(cfg_layout_b_i),
    .word_i    (word_q),
    .out_a_o   (out_a_o),
    .out_b_o   (out_b_o)
  );
endmodule

// File: rtl/cmd_reg_buffer_chk.sv
module cmd_reg_buffer_chk #(
  parameter int unsigned WIDE_W   = 25,
  parameter int unsigned NARROW_W = 14
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cfg_fan_i,
  input logic                cfg_layout_b_i,
  input logic                dcs_ni,
  input logic                csr_ni,
  input logic [WIDE_W-1:0]   data_i,
  input logic [WIDE_W-1:0]   out_a_o,
  input logic [NARROW_W-1:0] out_b_o
);
  logic [NARROW_W-1:0] data_rev;
  always_comb
    for (int i = 0; i < int'(NARROW_W); i++) data_rev[NARROW_W-1-i] = data_i[i];

  AST_WIDE_B_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_fan_i |-> out_b_o == '0); // R2
  AST_WIDE_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_fan_i && $past(rst_ni) && $past(!(dcs_ni && csr_ni))) |-> out_a_o == $past(data_i)); // R7
  AST_FAN_A_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_fan_i && !cfg_layout_b_i && $past(rst_ni) && $past(!(dcs_ni && csr_ni)))
    |-> out_b_o == $past(data_i[NARROW_W-1:0]) && out_a_o[NARROW_W-1:0] == $past(data_i[NARROW_W-1:0])); // R3
  AST_FAN_B_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_fan_i && cfg_layout_b_i && $past(rst_ni) && $past(!(dcs_ni && csr_ni)))
    |-> out_b_o == $past(data_rev) && out_a_o[NARROW_W-1:0] == $past(data_rev)); // R4
  AST_FAN_UPPER_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_fan_i |-> out_a_o[WIDE_W-1:NARROW_W] == '0); // R5
  AST_GATED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(dcs_ni && csr_ni) && $stable(cfg_fan_i) && $stable(cfg_layout_b_i))
    |-> $stable(out_a_o) && $stable(out_b_o)); // R6
endmodule

bind cmd_reg_buffer cmd_reg_buffer_chk #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_fan_i(cfg_fan_i), .cfg_layout_b_i(cfg_layout_b_i),
  .dcs_ni(dcs_ni), .csr_ni(csr_ni), .data_i(data_i), .out_a_o(out_a_o), .out_b_o(out_b_o)
);

// File: tb/tb_cmd_reg_buffer.sv
module tb_cmd_reg_buffer;
  localparam int unsigned W = 25;
  localparam int unsigned N = 14;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b1;
  logic         cfg_fan_i = 1'b0;
  logic         cfg_layout_b_i = 1'b0;
  logic         dcs_ni = 1'b0;
  logic         csr_ni = 1'b0;
  logic [W-1:0] data_i = '0;
  logic [W-1:0] out_a_o;
  logic [N-1:0] out_b_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [W-1:0] exp_word = '0;

  always #2 clk_i = ~clk_i;

  cmd_reg_buffer #(.WIDE_W(W), .NARROW_W(N)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_fan_i(cfg_fan_i), .cfg_layout_b_i(cfg_layout_b_i),
    .dcs_ni(dcs_ni), .csr_ni(csr_ni), .data_i(data_i), .out_a_o(out_a_o), .out_b_o(out_b_o)
  );

  function automatic logic [W-1:0] model_a(input logic [W-1:0] w, input logic fan, input logic lb);
    logic [W-1:0] r;
    if (!fan) return w;
    r = '0;
    for (int i = 0; i < int'(N); i++) r[lb ? N-1-i : i] = w[i];
    return r;
  endfunction

  function automatic logic [N-1:0] model_b(input logic [W-1:0] w, input logic fan, input logic lb);
    logic [N-1:0] r;
    r = '0;
    if (fan) for (int i = 0; i < int'(N); i++) r[lb ? N-1-i : i] = w[i];
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] ea, input logic [N-1:0] eb);
    checks++;
    if (out_a_o !== ea || out_b_o !== eb) begin
      errors++;
      $display("FAIL %s: out_a=%h out_b=%h expected out_a=%h out_b=%h", req, out_a_o, out_b_o, ea, eb);
    end
  endtask

  task automatic check_model(input string req);
    check(req, model_a(exp_word, cfg_fan_i, cfg_layout_b_i), model_b(exp_word, cfg_fan_i, cfg_layout_b_i));
  endtask

  // drive at negedge, capture at posedge, sample at next negedge
  task automatic step(input logic [W-1:0] d, input logic dcs, input logic csr);
    @(negedge clk_i);
    data_i = d; dcs_ni = dcs; csr_ni = csr;
    @(posedge clk_i);
    if (rst_ni && !(dcs && csr)) exp_word = d;
    @(negedge clk_i);
  endtask

  task automatic t_reset_state;
    #1 rst_ni = 1'b0;
    #1 check("R1 initial reset", '0, '0);
    step(25'h1ABCDEF, 1'b0, 1'b0);
    exp_word = '0;
    check("R1 held reset", '0, '0);
    rst_ni = 1'b1;
  endtask

  task automatic t_wide;
    cfg_fan_i = 1'b0;
    step(25'h1ABCDEF, 1'b0, 1'b0); check_model("R2 wide word 1");
    step(25'h0543210, 1'b0, 1'b0); check_model("R2 wide word 2");
    check("R2 wide out_b zero", 25'h0543210, '0);
  endtask

  task automatic t_fan_a;
    cfg_fan_i = 1'b1; cfg_layout_b_i = 1'b0;
    step(25'h0001235, 1'b0, 1'b0); check_model("R3 layout A");
    check("R3 layout A explicit", 25'h0001235, 14'h1235);
    step(25'h0002C01, 1'b1, 1'b0); check_model("R3 layout A second");
  endtask

  task automatic t_fan_b;
    cfg_fan_i = 1'b1; cfg_layout_b_i = 1'b1;
    step(25'h0000001, 1'b0, 1'b0);
    check("R4 layout B bit0", {11'h0, 14'h2000}, 14'h2000);
    step(25'h0001235, 1'b0, 1'b0); check_model("R4 layout B word");
  endtask

  task automatic t_fan_upper;
    cfg_fan_i = 1'b1; cfg_layout_b_i = 1'b0;
    step(25'h1FFC000, 1'b0, 1'b0);
    check("R5 upper bits ignored", '0, '0);
    step(25'h1FFC00F, 1'b0, 1'b0);
    check("R5 upper zero lower used", 25'h000000F, 14'h000F);
  endtask

  task automatic t_hold;
    cfg_fan_i = 1'b0;
    step(25'h0F0F0F0, 1'b0, 1'b0);
    step(25'h1111111, 1'b1, 1'b1); check("R6 hold first edge", 25'h0F0F0F0, '0);
    step(25'h0222222, 1'b1, 1'b1); check("R6 hold second edge", 25'h0F0F0F0, '0);
  endtask

  task automatic t_select_low;
    cfg_fan_i = 1'b0;
    step(25'h0333333, 1'b1, 1'b0); check("R7 csr low dcs high", 25'h0333333, '0);
    step(25'h0444444, 1'b0, 1'b1); check("R7 dcs low csr high", 25'h0444444, '0);
    step(25'h0555555, 1'b0, 1'b0); check("R7 both low", 25'h0555555, '0);
  endtask

  task automatic t_reset_over_gate;
    cfg_fan_i = 1'b0;
    step(25'h1234567, 1'b0, 1'b0);
    step(25'h0, 1'b1, 1'b1);
    @(posedge clk_i); #1 rst_ni = 1'b0;
    #0.5 exp_word = '0;
    check("R8 async clear while gated", '0, '0);
    step(25'h1777777, 1'b1, 1'b1); check("R8 reset held gated", '0, '0);
    step(25'h1777777, 1'b0, 1'b0); exp_word = '0; check("R8 reset held open", '0, '0);
  endtask

  task automatic t_release;
    cfg_fan_i = 1'b0;
    @(negedge clk_i); data_i = '0; dcs_ni = 1'b0; csr_ni = 1'b0;
    #1 rst_ni = 1'b1;
    for (int k = 0; k < 4; k++) begin
      step('0, 1'b0, 1'b0); check("R9 zero after release", '0, '0);
    end
    step(25'h0000080, 1'b0, 1'b0); check("R9 first nonzero", 25'h0000080, '0);
  endtask

  initial begin
    t_reset_state();
    t_wide();
    t_fan_a();
    t_fan_b();
    t_fan_upper();
    t_hold();
    t_select_low();
    t_reset_over_gate();
    t_release();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule